// File: doc/BRIEF.md
# Counted I2C Master Transfer Sequencer

This block runs one I2C master transfer at a time, under the control of a 16-bit control register and a programmed byte count. When software sets the start bit with the block enabled and in master role, the sequencer asks a byte-level bus agent for an address phase to the slave address. The read/write direction of that phase is the inverse of the transmit bit. After an acknowledged address, the sequencer moves bytes one at a time between the bus agent and two small byte FIFOs. The transmit FIFO is filled by the host. The receive FIFO is drained by the host.

A counted transfer ends when the remaining count reaches zero. If the stop bit is set, the block asks for a stop condition and releases the bus. If the stop bit is clear, the block keeps the bus, pulses an access-ready event and drops its master bit, so that software can follow with a repeated start. Repeat mode ignores the count and streams data until software sets stop. A not-acknowledge, on the address or on data, pulses a NACK event and cancels any pending stop.

The bus agent handles line timing. It sees one request at a time. The request is held stable until the agent pulses done, and the agent returns an acknowledge bit and, for reads, a byte.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset the control readback and count readback are zero, and no bus request, bus-held, transmit-ready or receive-ready output is high.
- R2: A control write (select 0) stores the data ANDed with 0xCF87. Bit 15 is enable, 14 byte order, 10 master, 9 transmit, 8 ten-bit addressing, 2 repeat, 1 stop and 0 start.
- R3: A control write with the start bit launches nothing unless enable and master are set and ten-bit addressing is clear.
- R4: An accepted start clears the start bit and empties both FIFOs. It then requests op START (code 0) with bus_rnw equal to the inverse of the transmit bit, and holds the request and op stable until done.
- R5: A NACK on the address phase pulses ev_nack, clears the stop bit, sends no data and leaves bus_busy low.
- R6: An ACK on the address phase raises bus_busy and loads the remaining count from the programmed count (select 1 write).
- R7: In a counted transmit, the FIFO bytes go out in push order as op SEND (code 1), one per handshake, and each one decrements the remaining count. tx_ready is high while the count is nonzero and the bus is in data phase.
- R8: In a counted receive, op RECV (code 2) is requested while the count is nonzero and the receive FIFO holds fewer than 4 bytes. Host pops let it resume. rx_ready is high whenever a byte is held, and bytes come out in arrival order.
- R9: When the count reaches zero with stop set, the block requests op STOP (code 3). After done it clears stop, reloads the remaining count, discards pending transmit bytes and drops bus_busy.
- R10: When the count reaches zero with stop clear, the block pulses ev_done, clears the master bit, keeps bus_busy high and issues no further request.
- R11: A NACK on a data byte pulses ev_nack, clears stop, stops further data and keeps bus_busy high.
- R12: In repeat mode the count is neither checked nor changed. Transmit sends every pending byte and then raises tx_ready. Receive fills the FIFO to 4 bytes and then raises rx_ready. Setting stop requests STOP at once.
- R13: The count readback shows the remaining count, not the programmed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects programmed count |
| reg_wdata | input | 16 | Register write data |
| ctrl_rd | output | 16 | Control register readback |
| count_rd | output | CNT_W | Remaining byte count |
| slave_addr | input | 7 | Target address for the address phase |
| tx_wr | input | 1 | Push one byte into the transmit FIFO |
| tx_byte | input | 8 | Byte to push |
| tx_level | output | LVL_W | Bytes pending in the transmit FIFO |
| rx_rd | input | 1 | Pop one byte from the receive FIFO |
| rx_byte | output | 8 | Oldest received byte |
| rx_level | output | LVL_W | Bytes held in the receive FIFO |
| tx_ready | output | 1 | Transmit-ready level |
| rx_ready | output | 1 | Receive-ready level |
| ev_nack | output | 1 | One-cycle pulse on a not-acknowledge |
| ev_done | output | 1 | One-cycle access-ready pulse |
| bus_busy | output | 1 | Bus is held by this master |
| bus_req | output | 1 | Command request to the bus agent |
| bus_op | output | 2 | Command: 0 START, 1 SEND, 2 RECV, 3 STOP |
| bus_rnw | output | 1 | Direction for START, 1 = read |
| bus_addr | output | 7 | Address for START |
| bus_wbyte | output | 8 | Byte for SEND |
| bus_done | input | 1 | Agent completion pulse |
| bus_ack | input | 1 | Acknowledge seen for START or SEND |
| bus_rbyte | input | 8 | Byte returned by RECV |

## Verification
The hardest case to reach is a not-acknowledge on a data byte in the middle of a counted transmit while a stop is pending. The bench's bus agent reaches it by refusing the acknowledge on a chosen command index, so the bytes before it go through normally. A receive stall at a full FIFO with count still remaining is the other delicate case. It is reached by issuing a long counted read and withholding host pops until the FIFO holds four bytes. The pops are then released one at a time while the scoreboard expects exactly one more read command per pop.

// File: rtl/i2cseq_pkg.sv
`timescale 1ns/1ps
package i2cseq_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RUN,
        ST_XFER,
        ST_STOP,
        ST_HOLD
    } seq_state_e;

    localparam int CB_EN  = 15;
    localparam int CB_MST = 10;
    localparam int CB_TRX = 9;
    localparam int CB_XA  = 8;
    localparam int CB_RM  = 2;
    localparam int CB_STP = 1;
    localparam int CB_STT = 0;
    localparam logic [15:0] CTRL_MASK = 16'hCF87;
endpackage

// File: rtl/seq_fifo.sv
`timescale 1ns/1ps
module seq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [LVL_W-1:0]        lvl;
    } fifo_t;

    fifo_t q, d;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    logic do_pop, do_push;

    always_comb begin
        d       = q;
        do_pop  = pop && (q.lvl != '0);
        do_push = push && ((q.lvl != LVL_MAX) || do_pop);
        if (clr) begin
            d.wp  = '0;
            d.rp  = '0;
            d.lvl = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wp] = din;
                d.wp        = nxt(q.wp);
            end
            if (do_pop) begin
                d.rp = nxt(q.rp);
            end
            case ({do_push, do_pop})
                2'b10:   d.lvl = q.lvl + LVL_W'(1);
                2'b01:   d.lvl = q.lvl - LVL_W'(1);
                default: d.lvl = q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout  = q.mem[q.rp];
    assign level = q.lvl;

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_MAX); // R8
    AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_MAX) && push && !pop && !clr |=> level == LVL_MAX); // R8
endmodule

// File: rtl/seq_regs.sv
`timescale 1ns/1ps
module seq_regs
    import i2cseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [15:0]      reg_wdata,
    input  logic             clr_stt,
    input  logic             clr_stp,
    input  logic             clr_mst,
    output logic [15:0]      ctrl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             start_go,
    output logic             start_trx
);
    typedef struct packed {
        logic [15:0]      ctrl;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (reg_wr) begin
            if (!reg_sel) d.ctrl = reg_wdata & CTRL_MASK;
            else          d.cnt  = reg_wdata[CNT_W-1:0];
        end
        if (clr_stt) d.ctrl[CB_STT] = 1'b0;
        if (clr_stp) d.ctrl[CB_STP] = 1'b0;
        if (clr_mst) d.ctrl[CB_MST] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_go  = reg_wr && !reg_sel && reg_wdata[CB_EN] && reg_wdata[CB_MST]
                       && !reg_wdata[CB_XA] && reg_wdata[CB_STT];
    assign start_trx = reg_wdata[CB_TRX];
    assign ctrl_o    = q.ctrl;
    assign cnt_o     = q.cnt;

    AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !reg_sel |=> (ctrl_o & ~CTRL_MASK) == 16'h0); // R2
endmodule

// File: rtl/seq_fsm.sv
`timescale 1ns/1ps
module seq_fsm
    import i2cseq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_go,
    input  logic             start_trx,
    input  logic             trx_i,
    input  logic             rm_i,
    input  logic             stp_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             tx_empty_i,
    input  logic [7:0]       tx_head_i,
    input  logic             rx_full_i,
    input  logic             rx_empty_i,
    input  logic             bus_done_i,
    input  logic             bus_ack_i,
    output logic             bus_req_o,
    output logic [1:0]       bus_op_o,
    output logic             bus_rnw_o,
    output logic [7:0]       bus_wbyte_o,
    output logic             tx_pop_o,
    output logic             tx_clr_o,
    output logic             rx_push_o,
    output logic             rx_clr_o,
    output logic             clr_stt_o,
    output logic             clr_stp_o,
    output logic             clr_mst_o,
    output logic             ev_nack_o,
    output logic             ev_done_o,
    output logic [CNT_W-1:0] cur_o,
    output logic             busy_o,
    output logic             tx_ready_o,
    output logic             rx_ready_o
);
    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cur;
        logic             busy;
        bus_op_e          op;
        logic             rnw;
        logic [7:0]       wbyte;
        logic             nack;
        logic             done;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d          = q;
        d.nack     = 1'b0;
        d.done     = 1'b0;
        tx_pop_o   = 1'b0;
        tx_clr_o   = 1'b0;
        rx_push_o  = 1'b0;
        rx_clr_o   = 1'b0;
        clr_stt_o  = 1'b0;
        clr_stp_o  = 1'b0;
        clr_mst_o  = 1'b0;
        case (q.state)
            ST_IDLE, ST_HOLD: begin
                if (start_go) begin
                    d.state   = ST_ADDR;
                    d.op      = OP_START;
                    d.rnw     = ~start_trx;
                    tx_clr_o  = 1'b1;
                    rx_clr_o  = 1'b1;
                    clr_stt_o = 1'b1;
                end
            end
            ST_ADDR: begin
                if (bus_done_i) begin
                    if (bus_ack_i) begin
                        d.busy  = 1'b1;
                        d.cur   = cnt_i;
                        d.state = ST_RUN;
                    end else begin
                        d.nack    = 1'b1;
                        clr_stp_o = 1'b1;
                        d.busy    = 1'b0;
                        d.state   = ST_IDLE;
                    end
                end
            end
            ST_RUN: begin
                if (stp_i && (rm_i || (q.cur == '0))) begin
                    d.state = ST_STOP;
                    d.op    = OP_STOP;
                end else if (!rm_i && (q.cur == '0)) begin
                    d.done    = 1'b1;
                    clr_mst_o = 1'b1;
                    d.state   = ST_HOLD;
                end else if (trx_i) begin
                    if (!tx_empty_i) begin
                        d.state = ST_XFER;
                        d.op    = OP_SEND;
                        d.wbyte = tx_head_i;
                    end
                end else if (!rx_full_i) begin
                    d.state = ST_XFER;
                    d.op    = OP_RECV;
                end
            end
            ST_XFER: begin
                if (bus_done_i) begin
                    if (!rm_i) d.cur = q.cur - CNT_W'(1);
                    if (q.op == OP_SEND) begin
                        tx_pop_o = 1'b1;
                        if (bus_ack_i) begin
                            d.state = ST_RUN;
                        end else begin
                            d.nack    = 1'b1;
                            clr_stp_o = 1'b1;
                            d.state   = ST_HOLD;
                        end
                    end else begin
                        rx_push_o = 1'b1;
                        d.state   = ST_RUN;
                    end
                end
            end
            ST_STOP: begin
                if (bus_done_i) begin
                    clr_stp_o = 1'b1;
                    tx_clr_o  = 1'b1;
                    d.cur     = cnt_i;
                    d.busy    = 1'b0;
                    d.state   = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.op    <= OP_START;
        end else begin
            q <= d;
        end
    end

    assign bus_req_o   = (q.state == ST_ADDR) || (q.state == ST_XFER) || (q.state == ST_STOP);
    assign bus_op_o    = q.op;
    assign bus_rnw_o   = q.rnw;
    assign bus_wbyte_o = q.wbyte;
    assign ev_nack_o   = q.nack;
    assign ev_done_o   = q.done;
    assign cur_o       = q.cur;
    assign busy_o      = q.busy;
    assign tx_ready_o  = ((q.state == ST_RUN) || (q.state == ST_XFER)) && trx_i
                         && (rm_i ? tx_empty_i : (q.cur != '0));
    assign rx_ready_o  = rm_i ? rx_full_i : !rx_empty_i;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_done_i |=> bus_req_o && $stable(bus_op_o)); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && bus_done_i && !rm_i && (bus_op_o == OP_SEND || bus_op_o == OP_RECV)
        |=> cur_o == $past(cur_o) - CNT_W'(1)); // R7
    AST_REPEAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && bus_done_i && rm_i && (bus_op_o == OP_SEND || bus_op_o == OP_RECV)
        |=> $stable(cur_o)); // R12
    AST_DONE_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done_o |-> busy_o && !bus_req_o); // R10
    AST_TXRDY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> busy_o); // R7
endmodule

// File: rtl/i2c_xfer_seq.sv
`timescale 1ns/1ps
module i2c_xfer_seq
    import i2cseq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      ctrl_rd,
    output logic [CNT_W-1:0] count_rd,
    input  logic [6:0]       slave_addr,
    input  logic             tx_wr,
    input  logic [7:0]       tx_byte,
    output logic [LVL_W-1:0] tx_level,
    input  logic             rx_rd,
    output logic [7:0]       rx_byte,
    output logic [LVL_W-1:0] rx_level,
    output logic             tx_ready,
    output logic             rx_ready,
    output logic             ev_nack,
    output logic             ev_done,
    output logic             bus_busy,
    output logic             bus_req,
    output logic [1:0]       bus_op,
    output logic             bus_rnw,
    output logic [6:0]       bus_addr,
    output logic [7:0]       bus_wbyte,
    input  logic             bus_done,
    input  logic             bus_ack,
    input  logic [7:0]       bus_rbyte
);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

    logic             clr_stt, clr_stp, clr_mst;
    logic             start_go, start_trx;
    logic [CNT_W-1:0] cnt_prog;
    logic             tx_pop, tx_clr, rx_push, rx_clr;
    logic [7:0]       tx_head;

    seq_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .clr_stt   (clr_stt),
        .clr_stp   (clr_stp),
        .clr_mst   (clr_mst),
        .ctrl_o    (ctrl_rd),
        .cnt_o     (cnt_prog),
        .start_go  (start_go),
        .start_trx (start_trx)
    );

    seq_fifo #(.W(8), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_txf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (tx_wr),
        .din   (tx_byte),
        .pop   (tx_pop),
        .dout  (tx_head),
        .level (tx_level)
    );

    seq_fifo #(.W(8), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_push),
        .din   (bus_rbyte),
        .pop   (rx_rd),
        .dout  (rx_byte),
        .level (rx_level)
    );

    seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_go    (start_go),
        .start_trx   (start_trx),
        .trx_i       (ctrl_rd[CB_TRX]),
        .rm_i        (ctrl_rd[CB_RM]),
        .stp_i       (ctrl_rd[CB_STP]),
        .cnt_i       (cnt_prog),
        .tx_empty_i  (tx_level == '0),
        .tx_head_i   (tx_head),
        .rx_full_i   (rx_level == LVL_FULL),
        .rx_empty_i  (rx_level == '0),
        .bus_done_i  (bus_done),
        .bus_ack_i   (bus_ack),
        .bus_req_o   (bus_req),
        .bus_op_o    (bus_op),
        .bus_rnw_o   (bus_rnw),
        .bus_wbyte_o (bus_wbyte),
        .tx_pop_o    (tx_pop),
        .tx_clr_o    (tx_clr),
        .rx_push_o   (rx_push),
        .rx_clr_o    (rx_clr),
        .clr_stt_o   (clr_stt),
        .clr_stp_o   (clr_stp),
        .clr_mst_o   (clr_mst),
        .ev_nack_o   (ev_nack),
        .ev_done_o   (ev_done),
        .cur_o       (count_rd),
        .busy_o      (bus_busy),
        .tx_ready_o  (tx_ready),
        .rx_ready_o  (rx_ready)
    );

    assign bus_addr = slave_addr;

    AST_NACK_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack && !$past(reg_wr) |-> !ctrl_rd[CB_STP]); // R11
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_done && (bus_op == OP_STOP) |=> !bus_busy); // R9
    AST_NO_REQ_WHEN_IDLE_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req && !bus_busy && !start_go |=> !bus_req); // R3
endmodule

// File: tb/sim_i2c_xfer_seq.sv
`timescale 1ns/1ps
module sim_i2c_xfer_seq;
    localparam int CNT_W = 16;
    localparam int DEPTH = 4;
    localparam int LVL_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_sel = 1'b0;
    logic [15:0]      reg_wdata = '0;
    logic [15:0]      ctrl_rd;
    logic [CNT_W-1:0] count_rd;
    logic [6:0]       slave_addr = 7'h2A;
    logic             tx_wr = 1'b0;
    logic [7:0]       tx_byte = '0;
    logic [LVL_W-1:0] tx_level;
    logic             rx_rd = 1'b0;
    logic [7:0]       rx_byte;
    logic [LVL_W-1:0] rx_level;
    logic             tx_ready, rx_ready, ev_nack, ev_done, bus_busy;
    logic             bus_req;
    logic [1:0]       bus_op;
    logic             bus_rnw;
    logic [6:0]       bus_addr;
    logic [7:0]       bus_wbyte;
    logic             bus_done = 1'b0;
    logic             bus_ack = 1'b1;
    logic [7:0]       bus_rbyte = '0;

    i2c_xfer_seq #(.CNT_W(CNT_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u0 (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    int cmd_idx = 0;
    int nack_idx = -1;
    int rx_seq = 0;
    int nack_cnt = 0;
    int done_cnt = 0;
    int dly = 0;
    logic [15:0] item, e;
    string tag;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    // bus agent and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_done = 1'b0;
            dly = 0;
        end else if (bus_done) begin
            bus_done = 1'b0;
            dly = 0;
        end else if (bus_req) begin
            dly++;
            if (dly >= 2) begin
                case (bus_op)
                    2'd0:    begin item = {8'h00, bus_rnw, bus_addr}; tag = "R4 start cmd"; end
                    2'd1:    begin item = {8'h01, bus_wbyte};         tag = "R7 send cmd";  end
                    2'd2:    begin item = 16'h0200;                  tag = "R8 recv cmd";  end
                    default: begin item = 16'h0300;                  tag = "R9 stop cmd";  end
                endcase
                if (exp_q.size() == 0) begin
                    chk(1'b0, {tag, " unexpected"}, int'(item), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(item == e, tag, int'(item), int'(e));
                end
                bus_ack = (cmd_idx != nack_idx);
                if (bus_op == 2'd2) begin
                    bus_rbyte = 8'hA0 + 8'(rx_seq);
                    rx_seq++;
                end
                cmd_idx++;
                bus_done = 1'b1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (ev_nack) nack_cnt++;
            if (ev_done) done_cnt++;
        end
    end

    task automatic wr_reg(input logic sel, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        tx_wr = 1'b1; tx_byte = b;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pop_rx(input logic [7:0] expb, input string req);
        @(negedge clk);
        chk(rx_byte == expb, req, int'(rx_byte), int'(expb));
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic wait_quiet(input string req);
        int n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !bus_req) n++;
            else n = 0;
            if (n >= 4) break;
        end
        chk(exp_q.size() == 0 && !bus_req, req, exp_q.size(), 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        int n0, d0, c0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctrl_rd == 16'h0, "R1 ctrl reset", ctrl_rd, 0);
        chk(count_rd == '0, "R1 count reset", count_rd, 0);
        chk(!bus_req && !bus_busy && !tx_ready && !rx_ready, "R1 outputs idle",
            {bus_req, bus_busy, tx_ready, rx_ready}, 0);

        // R2 / R3: masking and blocked starts
        c0 = cmd_idx;
        wr_reg(1'b0, 16'hFFFF);
        chk(ctrl_rd == 16'hCF87, "R2 write mask", ctrl_rd, 16'hCF87);
        repeat (10) @(negedge clk);
        chk(!bus_req && cmd_idx == c0, "R3 ten-bit blocks start", bus_req, 0);
        wr_reg(1'b0, 16'h8001);
        repeat (10) @(negedge clk);
        chk(!bus_req && cmd_idx == c0, "R3 no master blocks start", bus_req, 0);
        wr_reg(1'b0, 16'h0000);

        // R5: address NACK
        wr_reg(1'b1, 16'd3);
        exp_q.push_back(16'h002A);
        nack_idx = cmd_idx;
        n0 = nack_cnt;
        wr_reg(1'b0, 16'h8603);
        wait_quiet("R5 addr nack drained");
        chk(nack_cnt == n0 + 1, "R5 nack event", nack_cnt - n0, 1);
        chk(ctrl_rd == 16'h8600, "R5 stop cleared", ctrl_rd, 16'h8600);
        chk(!bus_busy, "R5 bus not held", bus_busy, 0);

        // R4 R6 R7 R9: counted transmit with stop
        exp_q.push_back(16'h002A);
        wr_reg(1'b0, 16'h8603);
        for (int i = 0; i < 50 && !bus_busy; i++) @(negedge clk);
        chk(count_rd == 16'd3, "R6 count loaded", count_rd, 3);
        chk(ctrl_rd == 16'h8602, "R4 start bit cleared", ctrl_rd, 16'h8602);
        chk(tx_ready && !bus_req, "R7 waiting for data", {tx_ready, bus_req}, 2);
        exp_q.push_back(16'h0111);
        exp_q.push_back(16'h0122);
        exp_q.push_back(16'h0133);
        exp_q.push_back(16'h0300);
        push_tx(8'h11);
        push_tx(8'h22);
        push_tx(8'h33);
        push_tx(8'h44);
        wait_quiet("R7 tx sequence drained");
        chk(!bus_busy, "R9 bus released", bus_busy, 0);
        chk(ctrl_rd == 16'h8600, "R9 stop cleared", ctrl_rd, 16'h8600);
        chk(count_rd == 16'd3, "R9 count reloaded", count_rd, 3);
        chk(tx_level == '0, "R9 pending byte dropped", tx_level, 0);

        // R8 R10 R13: counted receive without stop
        wr_reg(1'b1, 16'd6);
        rx_seq = 0;
        exp_q.push_back(16'h00AA);
        for (int i = 0; i < 4; i++) exp_q.push_back(16'h0200);
        wr_reg(1'b0, 16'h8401);
        wait_quiet("R8 rx fill drained");
        chk(rx_level == 3'd4, "R8 fifo full stall", rx_level, 4);
        chk(rx_ready, "R8 rx ready", rx_ready, 1);
        chk(count_rd == 16'd2, "R13 remaining count", count_rd, 2);
        d0 = done_cnt;
        exp_q.push_back(16'h0200);
        exp_q.push_back(16'h0200);
        pop_rx(8'hA0, "R8 byte order 0");
        pop_rx(8'hA1, "R8 byte order 1");
        wait_quiet("R8 rx resume drained");
        chk(done_cnt == d0 + 1, "R10 access-ready event", done_cnt - d0, 1);
        chk(ctrl_rd == 16'h8000, "R10 master cleared", ctrl_rd, 16'h8000);
        chk(bus_busy, "R10 bus held", bus_busy, 1);
        chk(count_rd == '0, "R13 count at zero", count_rd, 0);
        for (int i = 0; i < 4; i++) pop_rx(8'hA2 + 8'(i), "R8 byte order tail");
        @(negedge clk);
        chk(!rx_ready, "R8 rx ready drops when empty", rx_ready, 0);

        // R11: data NACK with pending stop (repeated start from held bus)
        wr_reg(1'b1, 16'd5);
        exp_q.push_back(16'h002A);
        exp_q.push_back(16'h0101);
        exp_q.push_back(16'h0102);
        nack_idx = cmd_idx + 2;
        n0 = nack_cnt;
        wr_reg(1'b0, 16'h8603);
        push_tx(8'h01);
        push_tx(8'h02);
        wait_quiet("R11 nack sequence drained");
        chk(nack_cnt == n0 + 1, "R11 nack event", nack_cnt - n0, 1);
        chk(ctrl_rd == 16'h8600, "R11 stop cancelled", ctrl_rd, 16'h8600);
        chk(bus_busy, "R11 bus held", bus_busy, 1);
        chk(count_rd == 16'd3, "R11 count after nack", count_rd, 3);
        chk(!tx_ready, "R11 data halted", tx_ready, 0);

        // R12: repeat transmit ignores count
        wr_reg(1'b1, 16'd1);
        d0 = done_cnt;
        exp_q.push_back(16'h002A);
        exp_q.push_back(16'h015A);
        exp_q.push_back(16'h016B);
        exp_q.push_back(16'h017C);
        wr_reg(1'b0, 16'h8605);
        push_tx(8'h5A);
        push_tx(8'h6B);
        push_tx(8'h7C);
        wait_quiet("R12 repeat tx drained");
        chk(tx_ready && bus_busy, "R12 tx ready after drain", {tx_ready, bus_busy}, 3);
        chk(count_rd == 16'd1, "R12 count untouched", count_rd, 1);
        chk(done_cnt == d0, "R12 no access-ready", done_cnt - d0, 0);
        exp_q.push_back(16'h0300);
        wr_reg(1'b0, 16'h8606);
        wait_quiet("R12 stop drained");
        chk(!bus_busy && ctrl_rd == 16'h8604, "R12 stop ends repeat", ctrl_rd, 16'h8604);

        // R12: repeat receive fills to depth
        rx_seq = 0;
        exp_q.push_back(16'h00AA);
        for (int i = 0; i < 4; i++) exp_q.push_back(16'h0200);
        wr_reg(1'b0, 16'h8405);
        wait_quiet("R12 repeat rx drained");
        chk(rx_level == 3'd4 && rx_ready, "R12 rx full ready", rx_level, 4);
        exp_q.push_back(16'h0200);
        pop_rx(8'hA0, "R12 rx byte");
        wait_quiet("R12 repeat rx refill");
        chk(rx_level == 3'd4, "R12 refilled", rx_level, 4);
        exp_q.push_back(16'h0300);
        wr_reg(1'b0, 16'h8406);
        wait_quiet("R12 rx stop drained");
        chk(!bus_busy, "R12 rx stop released", bus_busy, 0);

        summary();
        $finish;
    end
endmodule